// File: doc/BRIEF.md
# Dual-Mode Sync Buffer Manager

This block arbitrates one shared data buffer between a network-side agent and a local-side agent. Configuration picks which side produces and which side consumes, and picks one of two behaviours. In buffered mode the block rotates three bank indices. The producer and the consumer never wait for each other, and a consumer that starts a read always receives the newest completed write. Data that was written but not yet read is overwritten without notice. In mailbox mode there is a single bank guarded by a full flag. A write can start only while the slot is empty and a read can start only while it is full, so nothing that is written is lost.

Each side signals the start and the end of its access with one-cycle strobes. The block answers with the bank index that side should use, an access-open flag, and a one-cycle interrupt pulse. The memory array and the address arithmetic sit outside this block. Configuration inputs are meant to hold still while reset is released. All outputs are registered and change on the clock edge that samples the strobe.

Top module: `sync_buf_mgr`

## Requirements
- R1: After reset the data flag, both open flags and both interrupts are 0. In buffered mode the producer bank is BANK_BASE, the consumer bank is BANK_BASE+2, and the spare bank is BANK_BASE+1. In mailbox mode both banks are BANK_BASE.
- R2: With `cfg_dir`=0 the network side produces and the local side consumes. With `cfg_dir`=1 the roles swap: bank outputs, open flags, interrupts and strobe meanings all follow the role.
- R3: In buffered mode (`cfg_mode`=0) a start strobe is always accepted, on either side, whatever the other side is doing. Producer and consumer banks always differ.
- R4: In buffered mode, an end strobe on an open write exchanges the producer bank with the spare bank, sets the data flag, closes the write, and pulses the consumer's interrupt for one cycle.
- R5: In buffered mode, a consumer start strobe while the data flag is 1 exchanges the consumer bank with the spare bank and clears the flag. While the flag is 0, the consumer keeps its current bank.
- R6: In buffered mode, when two writes complete before a read starts, the next read receives the bank of the later write.
- R7: In buffered mode, when a write ends in the same cycle as a read starts, the read receives the bank that was just completed and the data flag ends at 0.
- R8: A producer start strobe while its write is already open restarts the write. Nothing is published: no bank change, no flag change, no interrupt.
- R9: In mailbox mode (`cfg_mode`=1) a producer start is refused while the data flag (full) is 1, and a consumer start is refused while it is 0. A refused start leaves the open flag at 0.
- R10: In mailbox mode, ending an open write sets full and pulses the consumer interrupt. Ending an open read clears full and pulses the producer interrupt.
- R11: An end strobe on a side with no open access changes nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0 buffered, 1 mailbox |
| cfg_dir | input | 1 | 0 network produces, 1 local produces |
| net_start | input | 1 | Network-side access start strobe |
| net_end | input | 1 | Network-side access end strobe |
| loc_start | input | 1 | Local-side access start strobe |
| loc_end | input | 1 | Local-side access end strobe |
| net_bank | output | BANK_W | Bank index for the network side |
| loc_bank | output | BANK_W | Bank index for the local side |
| net_open | output | 1 | Network-side access accepted and open |
| loc_open | output | 1 | Local-side access accepted and open |
| data_flag | output | 1 | Buffered: unread data ready; mailbox: slot full |
| irq_net | output | 1 | One-cycle interrupt pulse to the network side |
| irq_loc | output | 1 | One-cycle interrupt pulse to the local side |

## Verification
The bench builds the block with BANK_W=3 and BANK_BASE=4. Every bank index is therefore offset from zero, so a rotation that drops the base, or a mailbox that reports a bank other than the base, shows up in the bank values. Each reset of the bench selects a different mode and direction, so the same strobe pattern reaches both role mappings. The sequences in buffered mode follow one chain of bank rotations from start to finish, so an exchange that goes wrong at any step also changes every index the bench expects after it.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   typedef enum logic {MODE_BUFFERED = 1'b0, MODE_MAILBOX = 1'b1} sbm_mode_e;
   typedef enum logic {DIR_NET2LOC = 1'b0, DIR_LOC2NET = 1'b1} sbm_dir_e;

   localparam int SIDE_NET = 0;
   localparam int SIDE_LOC = 1;
   localparam int NUM_SIDES = 2;
   localparam int TRIPLE_BANKS = 3;

   // True when the given side acts as producer under the given direction.
   function automatic logic side_is_producer(input int side, input logic dir);
      if (side == SIDE_NET) return (dir == DIR_NET2LOC);
      else                  return (dir == DIR_LOC2NET);
   endfunction
endpackage

// File: rtl/sbm_route.sv
module sbm_route #(
   parameter int BANK_W = 2
) (
   input  logic                                     dir,
   input  logic [sbm_pkg::NUM_SIDES-1:0]            side_start,
   input  logic [sbm_pkg::NUM_SIDES-1:0]            side_end,
   output logic                                     p_start,
   output logic                                     p_end,
   output logic                                     c_start,
   output logic                                     c_end,
   input  logic [BANK_W-1:0]                        p_bank,
   input  logic [BANK_W-1:0]                        c_bank,
   input  logic                                     p_open,
   input  logic                                     c_open,
   input  logic                                     p_irq,
   input  logic                                     c_irq,
   output logic [sbm_pkg::NUM_SIDES-1:0][BANK_W-1:0] side_bank,
   output logic [sbm_pkg::NUM_SIDES-1:0]            side_open,
   output logic [sbm_pkg::NUM_SIDES-1:0]            side_irq
);
   import sbm_pkg::*;

   localparam int PI_NET = SIDE_NET;
   localparam int PI_LOC = SIDE_LOC;

   always_comb begin
      if (dir == DIR_NET2LOC) begin
         p_start = side_start[PI_NET];
         p_end   = side_end[PI_NET];
         c_start = side_start[PI_LOC];
         c_end   = side_end[PI_LOC];
      end else begin
         p_start = side_start[PI_LOC];
         p_end   = side_end[PI_LOC];
         c_start = side_start[PI_NET];
         c_end   = side_end[PI_NET];
      end
   end

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      logic is_prod;
      always_comb begin
         is_prod      = side_is_producer(s, dir);
         side_bank[s] = is_prod ? p_bank : c_bank;
         side_open[s] = is_prod ? p_open : c_open;
         side_irq[s]  = is_prod ? p_irq  : c_irq;
      end
   end
endmodule

// File: rtl/sbm_triple.sv
module sbm_triple #(
   parameter int BANK_W    = 2,
   parameter int BANK_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              p_start,
   input  logic              p_end,
   input  logic              c_start,
   input  logic              c_end,
   output logic [BANK_W-1:0] p_bank,
   output logic [BANK_W-1:0] c_bank,
   output logic              p_open,
   output logic              c_open,
   output logic              fresh,
   output logic              irq_c
);
   localparam logic [BANK_W-1:0] B_WR  = BANK_W'(BANK_BASE);
   localparam logic [BANK_W-1:0] B_SPR = BANK_W'(BANK_BASE + 1);
   localparam logic [BANK_W-1:0] B_RD  = BANK_W'(BANK_BASE + 2);

   logic [BANK_W-1:0] wr_q, spr_q, rd_q, wr_n, spr_n, rd_n, tmp;
   logic              fresh_q, fresh_n, po_q, po_n, co_q, co_n, irq_q, irq_n;

   always_comb begin
      wr_n    = wr_q;
      spr_n   = spr_q;
      rd_n    = rd_q;
      fresh_n = fresh_q;
      po_n    = po_q;
      co_n    = co_q;
      irq_n   = 1'b0;
      tmp     = '0;
      // Producer: completion publishes before any new start reopens.
      if (p_end && po_q) begin
         tmp     = wr_n;
         wr_n    = spr_n;
         spr_n   = tmp;
         fresh_n = 1'b1;
         irq_n   = 1'b1;
         po_n    = 1'b0;
      end
      if (p_start) po_n = 1'b1;
      // Consumer: sees a completion of this same cycle.
      if (c_end && co_q) co_n = 1'b0;
      if (c_start) begin
         co_n = 1'b1;
         if (fresh_n) begin
            tmp   = rd_n;
            rd_n  = spr_n;
            spr_n = tmp;
         end
         fresh_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         wr_q    <= B_WR;
         spr_q   <= B_SPR;
         rd_q    <= B_RD;
         fresh_q <= 1'b0;
         po_q    <= 1'b0;
         co_q    <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         wr_q    <= wr_n;
         spr_q   <= spr_n;
         rd_q    <= rd_n;
         fresh_q <= fresh_n;
         po_q    <= po_n;
         co_q    <= co_n;
         irq_q   <= irq_n;
      end
   end

   assign p_bank = wr_q;
   assign c_bank = rd_q;
   assign p_open = po_q;
   assign c_open = co_q;
   assign fresh  = fresh_q;
   assign irq_c  = irq_q;
endmodule

// File: rtl/sbm_mailbox.sv
module sbm_mailbox #(
   parameter int BANK_W    = 2,
   parameter int BANK_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              p_start,
   input  logic              p_end,
   input  logic              c_start,
   input  logic              c_end,
   output logic [BANK_W-1:0] bank,
   output logic              p_open,
   output logic              c_open,
   output logic              full,
   output logic              irq_p,
   output logic              irq_c
);
   localparam logic [BANK_W-1:0] B_SLOT = BANK_W'(BANK_BASE);

   logic full_q, full_n, po_q, po_n, co_q, co_n;
   logic ip_q, ip_n, ic_q, ic_n;

   always_comb begin
      full_n = full_q;
      po_n   = po_q;
      co_n   = co_q;
      ip_n   = 1'b0;
      ic_n   = 1'b0;
      if (p_end && po_q) begin
         full_n = 1'b1;
         po_n   = 1'b0;
         ic_n   = 1'b1;
      end
      if (p_start && !full_q && !po_q) po_n = 1'b1;
      if (c_end && co_q) begin
         full_n = 1'b0;
         co_n   = 1'b0;
         ip_n   = 1'b1;
      end
      if (c_start && full_q && !co_q) co_n = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         full_q <= 1'b0;
         po_q   <= 1'b0;
         co_q   <= 1'b0;
         ip_q   <= 1'b0;
         ic_q   <= 1'b0;
      end else begin
         full_q <= full_n;
         po_q   <= po_n;
         co_q   <= co_n;
         ip_q   <= ip_n;
         ic_q   <= ic_n;
      end
   end

   assign bank   = B_SLOT;
   assign p_open = po_q;
   assign c_open = co_q;
   assign full   = full_q;
   assign irq_p  = ip_q;
   assign irq_c  = ic_q;
endmodule

// File: rtl/sync_buf_mgr.sv
module sync_buf_mgr #(
   parameter int BANK_W    = 2,
   parameter int BANK_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              cfg_dir,
   input  logic              net_start,
   input  logic              net_end,
   input  logic              loc_start,
   input  logic              loc_end,
   output logic [BANK_W-1:0] net_bank,
   output logic [BANK_W-1:0] loc_bank,
   output logic              net_open,
   output logic              loc_open,
   output logic              data_flag,
   output logic              irq_net,
   output logic              irq_loc
);
   import sbm_pkg::*;

   localparam int BANK_SPAN = 1 << BANK_W;

   if (BANK_W < 2) begin : g_chk_w
      $error("BANK_W must be at least 2");
   end
   if (BANK_BASE < 0 || BANK_BASE + TRIPLE_BANKS > BANK_SPAN) begin : g_chk_base
      $error("BANK_BASE leaves no room for three banks");
   end

   logic [NUM_SIDES-1:0]             side_start, side_end, side_open, side_irq;
   logic [NUM_SIDES-1:0][BANK_W-1:0] side_bank;
   logic p_start, p_end, c_start, c_end;
   logic [BANK_W-1:0] p_bank, c_bank, tb_p_bank, tb_c_bank, mb_bank;
   logic p_open, c_open, p_irq, c_irq, flag;
   logic tb_po, tb_co, tb_fresh, tb_irq_c;
   logic mb_po, mb_co, mb_full, mb_irq_p, mb_irq_c;
   logic buf_en, mbx_en;

   assign side_start = {loc_start, net_start};
   assign side_end   = {loc_end,   net_end};
   assign buf_en     = (cfg_mode == MODE_BUFFERED);
   assign mbx_en     = (cfg_mode == MODE_MAILBOX);

   sbm_route #(.BANK_W(BANK_W)) u_route (
      .dir(cfg_dir), .side_start(side_start), .side_end(side_end),
      .p_start(p_start), .p_end(p_end), .c_start(c_start), .c_end(c_end),
      .p_bank(p_bank), .c_bank(c_bank), .p_open(p_open), .c_open(c_open),
      .p_irq(p_irq), .c_irq(c_irq),
      .side_bank(side_bank), .side_open(side_open), .side_irq(side_irq)
   );

   sbm_triple #(.BANK_W(BANK_W), .BANK_BASE(BANK_BASE)) u_triple (
      .clk(clk), .rst_n(rst_n), .en(buf_en),
      .p_start(p_start), .p_end(p_end), .c_start(c_start), .c_end(c_end),
      .p_bank(tb_p_bank), .c_bank(tb_c_bank), .p_open(tb_po), .c_open(tb_co),
      .fresh(tb_fresh), .irq_c(tb_irq_c)
   );

   sbm_mailbox #(.BANK_W(BANK_W), .BANK_BASE(BANK_BASE)) u_mbx (
      .clk(clk), .rst_n(rst_n), .en(mbx_en),
      .p_start(p_start), .p_end(p_end), .c_start(c_start), .c_end(c_end),
      .bank(mb_bank), .p_open(mb_po), .c_open(mb_co), .full(mb_full),
      .irq_p(mb_irq_p), .irq_c(mb_irq_c)
   );

   always_comb begin
      if (mbx_en) begin
         p_bank = mb_bank;  c_bank = mb_bank;
         p_open = mb_po;    c_open = mb_co;
         p_irq  = mb_irq_p; c_irq  = mb_irq_c;
         flag   = mb_full;
      end else begin
         p_bank = tb_p_bank; c_bank = tb_c_bank;
         p_open = tb_po;     c_open = tb_co;
         p_irq  = 1'b0;      c_irq  = tb_irq_c;
         flag   = tb_fresh;
      end
   end

   assign net_bank  = side_bank[SIDE_NET];
   assign loc_bank  = side_bank[SIDE_LOC];
   assign net_open  = side_open[SIDE_NET];
   assign loc_open  = side_open[SIDE_LOC];
   assign irq_net   = side_irq[SIDE_NET];
   assign irq_loc   = side_irq[SIDE_LOC];
   assign data_flag = flag;
endmodule

// File: rtl/sync_buf_mgr_chk.sv
module sync_buf_mgr_chk #(
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mbx,
   input logic              p_start,
   input logic              p_end,
   input logic              c_start,
   input logic              c_end,
   input logic              p_open,
   input logic              c_open,
   input logic [BANK_W-1:0] p_bank,
   input logic [BANK_W-1:0] c_bank,
   input logic              flag,
   input logic              irq_c
);
   a_r3_banks_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !mbx |-> (p_bank != c_bank));

   a_r4_publish_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (!mbx && p_end && p_open) |=> irq_c);

   a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!mbx && p_start && p_open && !p_end && !c_start) |=> ($stable(flag) && $stable(p_bank) && !irq_c));

   a_r9_refuse_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mbx && flag && p_start && !p_open) |=> !p_open);

   a_r9_refuse_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mbx && !flag && c_start && !c_open) |=> !c_open);

   a_r9_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      mbx |-> (p_bank == c_bank));

   a_r10_full_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (mbx && $rose(flag)) |-> $past(p_end && p_open));

   a_r11_stray_end: assert property (@(posedge clk) disable iff (!rst_n)
      (p_end && !p_open && !p_start && !c_start && !c_end) |=> ($stable(flag) && !irq_c));
endmodule

bind sync_buf_mgr sync_buf_mgr_chk #(.BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mbx(mbx_en),
   .p_start(p_start), .p_end(p_end), .c_start(c_start), .c_end(c_end),
   .p_open(p_open), .c_open(c_open), .p_bank(p_bank), .c_bank(c_bank),
   .flag(flag), .irq_c(c_irq)
);

// File: tb/test_sync_buf_mgr.sv
module test_sync_buf_mgr;
   localparam int BW = 3;
   localparam int BASE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_mode = 1'b0, cfg_dir = 1'b0;
   logic net_start = 1'b0, net_end = 1'b0, loc_start = 1'b0, loc_end = 1'b0;
   logic [BW-1:0] net_bank, loc_bank;
   logic net_open, loc_open, data_flag, irq_net, irq_loc;

   always #2 clk = ~clk;

   sync_buf_mgr #(.BANK_W(BW), .BANK_BASE(BASE)) i_sync_buf_mgr (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
      .net_start(net_start), .net_end(net_end), .loc_start(loc_start), .loc_end(loc_end),
      .net_bank(net_bank), .loc_bank(loc_bank), .net_open(net_open), .loc_open(loc_open),
      .data_flag(data_flag), .irq_net(irq_net), .irq_loc(irq_loc)
   );

   typedef struct {
      int    nb, lb;
      bit    no, lo, fl, inet, iloc;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0, errors = 0;
   bit done = 1'b0;

   // Monitor: compares each cycle's outputs against the queued expectation.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (int'(net_bank) != e.nb || int'(loc_bank) != e.lb || net_open != e.no ||
             loc_open != e.lo || data_flag != e.fl || irq_net != e.inet || irq_loc != e.iloc) begin
            errors++;
            $display("FAIL %s: got nb=%0d lb=%0d no=%0b lo=%0b fl=%0b in=%0b il=%0b, expected nb=%0d lb=%0d no=%0b lo=%0b fl=%0b in=%0b il=%0b",
                     e.tag, net_bank, loc_bank, net_open, loc_open, data_flag, irq_net, irq_loc,
                     e.nb, e.lb, e.no, e.lo, e.fl, e.inet, e.iloc);
         end
      end
   end

   task automatic cyc(input bit ns, ne, ls, le, input int nb, lb,
                      input bit no, lo, fl, inet, iloc, input string tag);
      exp_t e;
      @(negedge clk);
      net_start = ns; net_end = ne; loc_start = ls; loc_end = le;
      e.nb = nb; e.lb = lb; e.no = no; e.lo = lo; e.fl = fl;
      e.inet = inet; e.iloc = iloc; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic do_reset(input bit mode, input bit dir);
      @(negedge clk);
      rst_n = 1'b0; cfg_mode = mode; cfg_dir = dir;
      net_start = 0; net_end = 0; loc_start = 0; loc_end = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #40000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got hang, expected completion");
         finish_run();
      end
   end

   initial begin
      // Buffered, network produces. Banks: write 4, spare 5, read 6.
      do_reset(1'b0, 1'b0);
      cyc(0,0,0,0, 4,6, 0,0,0,0,0, "R1 reset buffered");
      cyc(1,0,0,0, 4,6, 1,0,0,0,0, "R3 write start");
      cyc(0,1,0,0, 5,6, 0,0,1,0,1, "R4 write end publishes");
      cyc(0,0,0,0, 5,6, 0,0,1,0,0, "R4 irq single cycle");
      cyc(0,0,1,0, 5,4, 0,1,0,0,0, "R5 read takes fresh bank");
      cyc(1,0,0,0, 5,4, 1,1,0,0,0, "R3 write during read");
      cyc(0,1,0,0, 6,4, 0,1,1,0,1, "R3 publish during read");
      cyc(0,0,0,1, 6,4, 0,0,1,0,0, "R3 read end");
      cyc(1,0,0,0, 6,4, 1,0,1,0,0, "R6 second write start");
      cyc(0,1,0,0, 5,4, 0,0,1,0,1, "R6 overwrite unread");
      cyc(0,0,1,0, 5,6, 0,1,0,0,0, "R6 read gets latest");
      cyc(0,0,0,1, 5,6, 0,0,0,0,0, "R6 read end");
      cyc(0,0,1,0, 5,6, 0,1,0,0,0, "R5 no fresh keeps bank");
      cyc(0,0,0,1, 5,6, 0,0,0,0,0, "R5 read end");
      cyc(1,0,0,0, 5,6, 1,0,0,0,0, "R8 write start");
      cyc(1,0,0,0, 5,6, 1,0,0,0,0, "R8 restart no publish");
      cyc(0,0,0,0, 5,6, 1,0,0,0,0, "R8 still quiet");
      cyc(0,1,0,0, 4,6, 0,0,1,0,1, "R8 restarted write ends");
      cyc(0,0,1,0, 4,5, 0,1,0,0,0, "R5 read takes bank 5");
      cyc(0,0,0,1, 4,5, 0,0,0,0,0, "R5 read end");
      cyc(1,0,0,0, 4,5, 1,0,0,0,0, "R7 write start");
      cyc(0,1,1,0, 6,4, 0,1,0,0,1, "R7 same-cycle end and read");
      cyc(0,0,0,1, 6,4, 0,0,0,0,0, "R7 read end");
      cyc(0,1,0,0, 6,4, 0,0,0,0,0, "R11 stray write end");
      cyc(0,0,0,1, 6,4, 0,0,0,0,0, "R11 stray read end");

      // Buffered, local produces.
      do_reset(1'b0, 1'b1);
      cyc(0,0,0,0, 6,4, 0,0,0,0,0, "R1 R2 reset reversed");
      cyc(0,0,1,0, 6,4, 0,1,0,0,0, "R2 local write start");
      cyc(0,0,0,1, 6,5, 0,0,1,1,0, "R2 local publish irq to network");
      cyc(1,0,0,0, 4,5, 1,0,0,0,0, "R2 network read");
      cyc(0,1,0,0, 4,5, 0,0,0,0,0, "R2 network read end");

      // Mailbox, local produces.
      do_reset(1'b1, 1'b1);
      cyc(0,0,0,0, 4,4, 0,0,0,0,0, "R1 reset mailbox");
      cyc(1,0,0,0, 4,4, 0,0,0,0,0, "R9 read refused empty");
      cyc(0,0,1,0, 4,4, 0,1,0,0,0, "R9 write accepted");
      cyc(0,0,0,1, 4,4, 0,0,1,1,0, "R10 write end sets full");
      cyc(0,0,0,0, 4,4, 0,0,1,0,0, "R10 irq single cycle");
      cyc(0,0,1,0, 4,4, 0,0,1,0,0, "R9 write refused full");
      cyc(1,0,0,0, 4,4, 1,0,1,0,0, "R10 read accepted");
      cyc(0,1,0,0, 4,4, 0,0,0,0,1, "R10 read end frees slot");
      cyc(0,0,0,1, 4,4, 0,0,0,0,0, "R11 stray end mailbox");
      cyc(0,0,0,0, 4,4, 0,0,0,0,0, "R11 idle");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule